// File: doc/BRIEF.md
# Banked Register Window

This block gives a host many registers while it decodes only a 16-byte I/O window. The window holds eight 16-bit words. The top word is the bank selector, and it reads and writes the same way whichever bank is active. The other seven words mean different registers depending on the bank number held in that selector. The host bus is 16 bits wide. It has two byte-lane enables, so any register can be reached as a full word, as its even (low) byte alone, or as its odd (high) byte alone.

A host first writes the bank number into the selector word. It then reads or writes the word offsets of that bank. Reads are registered: the data appears on the cycle after the read strobe, and the output is zero in every other cycle. The block holds a demonstration set of read/write registers, each with a reset default. Lanes that are not enabled return zero. Bank and word combinations that have no register ignore writes and read as zero. The current bank number is also brought out, for the logic that sits behind the registers.

Top module: `bank_reg_port`

## Requirements
- R1: After a synchronous reset, the bank is 0 and register (bank b, word w) holds 16'hB000 | b<<8 | w<<4 | 4'h3.
- R2: Word address 7 is the selector in every bank. A read of it returns the identifying byte 8'h33 in bits 15:8, zeros in bits 7:3, and the current bank number in bits 2:0.
- R3: A write to word 7 with the low lane enabled loads the bank from wdata[2:0]. A write to word 7 with only the high lane enabled leaves the bank unchanged.
- R4: Word address w (0 to 6) selects the register of the current bank. The same word address in two different banks reaches separate storage.
- R5: A write updates only the enabled lanes: be[0] enables bits 7:0 and be[1] enables bits 15:8. The other byte keeps its value.
- R6: In read data, a lane whose enable is low reads as zero.
- R7: Words 5 and 6 in any bank, and every word in banks 4 to 7, have no register. Writes to them change no register, and reads from them return zero.
- R8: Read data appears in the cycle after the cycle in which rd_en is sampled high. In every cycle that does not follow a read, rdata is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| waddr | input | 3 | Word address within the window (byte address bits 3:1) |
| be | input | 2 | Byte-lane enables: bit 0 is the low byte, bit 1 is the high byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| bank | output | 3 | Current bank number |

## Verification
The bench builds the block with its default parameters: four populated banks of five words each, and a 3-bit bank field. With these values, all three kinds of empty location can be reached from the bus. These are the unpopulated words 5 and 6, the empty banks 4 to 7, and bank 5, which could alias onto bank 1 if the index arithmetic wrapped. The same build also covers writes that touch a single lane, lane-masked reads, and switches from one bank to another, each checked against register defaults computed from the reset formula.

// File: rtl/bank_port_pkg.sv
`timescale 1ns/1ps
package bank_port_pkg;
  localparam int DW    = 16;
  localparam int LANES = DW / 8;

  // Reset default of register (bank b, word w).
  function automatic logic [DW-1:0] reg_default(input int unsigned b, input int unsigned w);
    logic [3:0] bn;
    logic [3:0] wn;
    bn = b[3:0];
    wn = w[3:0];
    return {4'hB, bn, wn, 4'h3};
  endfunction
endpackage

// File: rtl/bank_decode.sv
`timescale 1ns/1ps
module bank_decode #(
  parameter int WAW        = 3,
  parameter int BANK_W     = 3,
  parameter int NUM_BANKS  = 4,
  parameter int IMPL_WORDS = 5,
  parameter int IDX_W      = 5
) (
  input  logic [WAW-1:0]    word_addr,
  input  logic [BANK_W-1:0] cur_bank,
  output logic              sel_bank_word,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int LAST_WORD = (1 << WAW) - 1;

  logic [31:0] flat;

  always_comb begin
    sel_bank_word = (word_addr == WAW'(LAST_WORD));
    hit = !sel_bank_word
          && (32'(cur_bank) < 32'(NUM_BANKS))
          && (32'(word_addr) < 32'(IMPL_WORDS));
    flat = 32'(cur_bank) * 32'(IMPL_WORDS) + 32'(word_addr);
    idx  = flat[IDX_W-1:0];
  end
endmodule

// File: rtl/bank_reg_file.sv
`timescale 1ns/1ps
module bank_reg_file
  import bank_port_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int IMPL_WORDS = 5,
  parameter int IDX_W      = 5
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     we,
  input  logic [IDX_W-1:0]                         idx,
  input  logic [LANES-1:0]                         be,
  input  logic [DW-1:0]                            wdata,
  output logic [NUM_BANKS*IMPL_WORDS-1:0][DW-1:0]  regs_q
);
  localparam int NREGS = NUM_BANKS * IMPL_WORDS;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int w = 0; w < IMPL_WORDS; w++)
          regs_q[b*IMPL_WORDS + w] <= reg_default(b, w);
    end else if (we) begin
      for (int i = 0; i < NREGS; i++)
        if (idx == IDX_W'(i))
          for (int l = 0; l < LANES; l++)
            if (be[l]) regs_q[i][8*l +: 8] <= wdata[8*l +: 8];
    end
  end
endmodule

// File: rtl/bank_read_mux.sv
`timescale 1ns/1ps
module bank_read_mux
  import bank_port_pkg::*;
#(
  parameter int          NREGS   = 20,
  parameter int          IDX_W   = 5,
  parameter int          BANK_W  = 3,
  parameter logic [7:0]  ID_BYTE = 8'h33
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [LANES-1:0]            be,
  input  logic                        sel_bank_word,
  input  logic                        hit,
  input  logic [IDX_W-1:0]            idx,
  input  logic [NREGS-1:0][DW-1:0]    regs_q,
  input  logic [BANK_W-1:0]           cur_bank,
  output logic [DW-1:0]               rdata
);
  logic [DW-1:0] word;
  logic [DW-1:0] lane_mask;

  always_comb begin
    word = '0;
    if (sel_bank_word)
      word = {ID_BYTE, {(8-BANK_W){1'b0}}, cur_bank};
    else if (hit && (32'(idx) < 32'(NREGS)))
      word = regs_q[idx];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign lane_mask[8*l +: 8] = {8{be[l]}};
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_en) rdata <= '0;
    else               rdata <= word & lane_mask;
  end
endmodule

// File: rtl/bank_reg_port.sv
`timescale 1ns/1ps
module bank_reg_port
  import bank_port_pkg::*;
#(
  parameter int         WIN_BYTES  = 16,
  parameter int         BANK_W     = 3,
  parameter int         NUM_BANKS  = 4,
  parameter int         IMPL_WORDS = 5,
  parameter logic [7:0] ID_BYTE    = 8'h33,
  localparam int        WAW        = $clog2(WIN_BYTES / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [WAW-1:0]    waddr,
  input  logic [1:0]        be,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic [BANK_W-1:0] bank
);
  localparam int NREGS = NUM_BANKS * IMPL_WORDS;
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic             sel_bank_word;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [NREGS-1:0][DW-1:0] regs_q;

  bank_decode #(
    .WAW(WAW), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS),
    .IMPL_WORDS(IMPL_WORDS), .IDX_W(IDX_W)
  ) u_dec (
    .word_addr(waddr), .cur_bank(bank),
    .sel_bank_word(sel_bank_word), .hit(hit), .idx(idx)
  );

  always_ff @(posedge clk) begin
    if (rst)                                  bank <= '0;
    else if (wr_en && sel_bank_word && be[0]) bank <= wdata[BANK_W-1:0];
  end

  bank_reg_file #(
    .NUM_BANKS(NUM_BANKS), .IMPL_WORDS(IMPL_WORDS), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(wr_en && hit), .idx(idx),
    .be(be), .wdata(wdata), .regs_q(regs_q)
  );

  bank_read_mux #(
    .NREGS(NREGS), .IDX_W(IDX_W), .BANK_W(BANK_W), .ID_BYTE(ID_BYTE)
  ) u_rmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .be(be),
    .sel_bank_word(sel_bank_word), .hit(hit), .idx(idx),
    .regs_q(regs_q), .cur_bank(bank), .rdata(rdata)
  );
endmodule

// File: rtl/bank_reg_port_chk.sv
`timescale 1ns/1ps
module bank_reg_port_chk #(
  parameter int         WAW     = 3,
  parameter int         BANK_W  = 3,
  parameter logic [7:0] ID_BYTE = 8'h33
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [WAW-1:0]    waddr,
  input logic [1:0]        be,
  input logic [15:0]       wdata,
  input logic [15:0]       rdata,
  input logic [BANK_W-1:0] bank
);
  localparam logic [WAW-1:0] SEL = '1;

  // R1
  reset_bank_chk: assert property (@(posedge clk) $fell(rst) |-> bank == '0);

  // R8
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> rdata == 16'h0);

  // R6
  lane_lo_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !be[0]) |-> rdata[7:0] == 8'h0);

  // R6
  lane_hi_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !be[1]) |-> rdata[15:8] == 8'h0);

  // R2
  id_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && waddr == SEL && be[1]) |-> rdata[15:8] == ID_BYTE);

  // R3
  bank_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && waddr == SEL && be[0]) |-> bank == $past(wdata[BANK_W-1:0]));

  // R3
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && waddr == SEL && be[0]) |-> $stable(bank));
endmodule

bind bank_reg_port bank_reg_port_chk #(
  .WAW(WAW), .BANK_W(BANK_W), .ID_BYTE(ID_BYTE)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .waddr(waddr),
  .be(be), .wdata(wdata), .rdata(rdata), .bank(bank)
);

// File: tb/bank_reg_port_tb.sv
`timescale 1ns/1ps
module bank_reg_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  waddr = '0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  bank;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        mon_rd;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  bank_reg_port u_dut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .waddr(waddr),
    .be(be), .wdata(wdata), .rdata(rdata), .bank(bank)
  );

  function automatic logic [15:0] dflt(input int b, input int w);
    return {4'hB, 4'(b), 4'(w), 4'h3};
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; waddr = a; be = b; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; be = '0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] b, input logic [15:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; waddr = a; be = b;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0; be = '0;
  endtask

  task automatic set_bank(input int b);
    wr(3'd7, 2'b01, {8'hFF, 8'(b)});
  endtask

  // Scoreboard monitor: samples 1 ns after the edge.
  always @(posedge clk) begin
    mon_rd = rd_en && !rst;
    #1;
    if (mon_rd) begin
      if (exp_q.size() == 0) check(rdata, 16'hDEAD, "R8 unexpected read data");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end else if (!rst && !done) begin
      check(rdata, 16'h0000, "R8 idle output");
    end
  end

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({13'd0, bank}, 16'd0, "R1 reset bank");
    for (int w = 0; w < 5; w++) rd(3'(w), 2'b11, dflt(0, w), "R1 bank0 default");
    rd(3'd7, 2'b11, 16'h3300, "R2 selector read bank0");

    set_bank(2);
    rd(3'd7, 2'b11, 16'h3302, "R3 bank load");
    wr(3'd7, 2'b10, 16'h0505);
    rd(3'd7, 2'b11, 16'h3302, "R3 high-lane selector write ignored");
    rd(3'd1, 2'b11, dflt(2, 1), "R4 bank2 default");

    wr(3'd1, 2'b11, 16'h1234);
    set_bank(0);
    rd(3'd1, 2'b11, dflt(0, 1), "R4 bank0 separate storage");
    set_bank(2);
    rd(3'd1, 2'b11, 16'h1234, "R4 bank2 written");

    wr(3'd2, 2'b01, 16'h77AB);
    rd(3'd2, 2'b11, {dflt(2, 2)}[15:8] == 8'h0 ? 16'h0 : {8'hB2, 8'hAB}, "R5 low lane only");
    wr(3'd2, 2'b10, 16'hCD99);
    rd(3'd2, 2'b11, 16'hCDAB, "R5 high lane only");
    rd(3'd2, 2'b01, 16'h00AB, "R6 low lane read");
    rd(3'd2, 2'b10, 16'hCD00, "R6 high lane read");
    rd(3'd7, 2'b01, 16'h0002, "R6 selector low lane");

    wr(3'd5, 2'b11, 16'hFFFF);
    rd(3'd5, 2'b11, 16'h0000, "R7 word5 unimplemented");
    rd(3'd6, 2'b11, 16'h0000, "R7 word6 unimplemented");
    set_bank(5);
    rd(3'd7, 2'b11, 16'h3305, "R2 selector visible in bank5");
    wr(3'd0, 2'b11, 16'hBEEF);
    rd(3'd0, 2'b11, 16'h0000, "R7 empty bank read");
    set_bank(1);
    rd(3'd0, 2'b11, dflt(1, 0), "R7 no alias into bank1");
    set_bank(3);
    rd(3'd4, 2'b11, dflt(3, 4), "R4 last populated word");
    rd(3'd0, 2'b00, 16'h0000, "R6 no lanes enabled");

    repeat (3) @(negedge clk);
    done = 1'b1;
    check(16'(exp_q.size()), 16'd0, "R8 all reads returned");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule